// File: doc/BRIEF.md
# Flash Erase-Block Bad-Marker Scanner

The scanner decides whether one erase block of a raw flash array carries a factory bad-block mark. A single-cycle start pulse supplies a block number and a policy select. The scanner reads the spare area of one or two pages of that block through a byte-stream read port and inspects each byte as it arrives. The read port takes a request (page, column, length) and returns a byte stream. The geometry is supplied at run time and captured at start: pages per block, spare bytes per page, and the main-area size that sets the spare column.

Two policies are supported. Full-spare mode reads the block's first and last page and treats any zero byte anywhere in a spare area as a bad mark. Legacy mode reads the first two pages of the block and looks only at the first spare byte of each. Scanning stops after the first page that shows a mark. A read that reports an error aborts the scan with an error result instead of a verdict.

Top module: `bad_block_scanner`

## Requirements
- R1: The first page requested is block number times pages-per-block, for both policies. Every request carries the column equal to the captured main-area size, which is the spare offset 0, and a length equal to the captured spare byte count. All bytes of that length are accepted.
- R2: With `scan_full_i` = 1 (full-spare mode), the second page requested is the first page plus pages-per-block minus 1. With one page per block, this is the same page read twice.
- R3: In full-spare mode, a page is marked when any of its spare bytes equals 0x00, whatever its position, including the last byte.
- R4: With `scan_full_i` = 0 (legacy mode), the second page requested is the first page plus 1.
- R5: In legacy mode, only spare byte 0 (the first byte of the stream) is examined. Zero bytes at any other position leave the verdict good.
- R6: Once a page's spare data has been fully received and that page is marked, the scan ends without requesting another page and reports bad. If no inspected page is marked, it reports good after the second page.
- R7: A byte beat with `rd_data_err_i` = 1 ends the scan at once: no further beats are accepted, no further page is requested, and the result is error with bad = 0. This holds even when the same beat carries a zero byte.
- R8: `scan_done_o` is a one-cycle pulse in the cycle after the final accepted beat. `scan_bad_o` and `scan_err_o` change only together with that pulse or in the cycle after an accepted start, which clears both. They hold their value in between.
- R9: A start pulse while a scan is running (`scan_busy_o` = 1) is ignored. The running scan keeps its block, pages and result.
- R10: A request stays asserted with stable page and length until `rd_req_ready_i`. Data ready is asserted only after the request is accepted, and never together with a request.
- R11: After reset, `scan_busy_o`, `scan_done_o`, `scan_bad_o`, `scan_err_o`, `rd_req_valid_o` and `rd_data_ready_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_start_i | input | 1 | Start pulse, taken only when idle |
| scan_block_i | input | BLK_W | Erase block number |
| scan_full_i | input | 1 | 1 = full-spare first/last policy, 0 = legacy byte-0 first/second policy |
| pages_per_blk_i | input | PPB_W | Pages per erase block (at least 1) |
| spare_bytes_i | input | SPR_W | Spare bytes per page (at least 1) |
| page_bytes_i | input | COL_W | Main-area bytes per page, used as the spare column |
| rd_req_valid_o | output | 1 | Spare read request valid |
| rd_req_ready_i | input | 1 | Spare read request accepted |
| rd_req_page_o | output | BLK_W+PPB_W | Requested page number |
| rd_req_col_o | output | COL_W | Requested start column |
| rd_req_len_o | output | SPR_W | Requested byte count |
| rd_data_valid_i | input | 1 | Byte beat valid |
| rd_data_ready_o | output | 1 | Scanner accepts byte beats |
| rd_data_i | input | 8 | Spare byte |
| rd_data_err_i | input | 1 | Read failure flagged on this beat |
| scan_busy_o | output | 1 | Scan in progress |
| scan_done_o | output | 1 | One-cycle completion pulse |
| scan_bad_o | output | 1 | Block marked bad |
| scan_err_o | output | 1 | Scan aborted by a read error |

## Verification
The error abort and the marker detection can both resolve on one accepted beat. A zero byte arriving with the error flag would set bad if marker detection won. The bench builds this case in legacy mode by flagging an error on byte 0 of the second page while that byte is also zero. The scoreboard expects an error result with bad clear and no further request. A second overlap is a start pulse arriving while the read port is streaming. The bench checks that the page list and verdict queued for the running scan are unchanged.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2
  } scan_state_e;

  typedef enum logic {
    POLICY_LEGACY = 1'b0,
    POLICY_FULL   = 1'b1
  } scan_policy_e;

endpackage

// File: rtl/bbs_page_sel.sv
module bbs_page_sel #(
  parameter int BLK_W  = 10,
  parameter int PPB_W  = 8,
  parameter int PAGE_W = BLK_W + PPB_W
) (
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [PPB_W-1:0]  ppb_i,
  input  logic              full_i,
  input  logic              second_i,
  output logic [PAGE_W-1:0] page_o
);
  import bbs_pkg::*;

  logic [PAGE_W-1:0] base_page;
  logic [PAGE_W-1:0] step;
  scan_policy_e      policy;

  always_comb begin
    policy    = scan_policy_e'(full_i);
    base_page = PAGE_W'(blk_i) * PAGE_W'(ppb_i);
    if (!second_i)
      step = '0;
    else if (policy == POLICY_FULL)
      step = PAGE_W'(ppb_i) - PAGE_W'(1);
    else
      step = PAGE_W'(1);
    page_o = base_page + step;
  end

endmodule

// File: rtl/bbs_byte_inspect.sv
module bbs_byte_inspect #(
  parameter int SPR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             beat_i,
  input  logic             full_i,
  input  logic [7:0]       data_i,
  input  logic [SPR_W-1:0] len_i,
  output logic             last_o,
  output logic             page_bad_o
);
  logic [SPR_W-1:0] cnt_q, cnt_d;
  logic             hit_q, hit_d;
  logic             zero_now;

  always_comb begin
    zero_now   = (data_i == 8'h00) && (full_i || (cnt_q == '0));
    last_o     = (cnt_q == (len_i - SPR_W'(1)));
    page_bad_o = hit_q | zero_now;
    cnt_d      = cnt_q;
    hit_d      = hit_q;
    if (clear_i) begin
      cnt_d = '0;
      hit_d = 1'b0;
    end else if (beat_i) begin
      cnt_d = cnt_q + SPR_W'(1);
      hit_d = page_bad_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hit_q <= hit_d;
    end
  end

endmodule

// File: rtl/bbs_ctrl.sv
module bbs_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic req_ready_i,
  input  logic data_valid_i,
  input  logic data_err_i,
  input  logic last_i,
  input  logic page_bad_i,
  output logic busy_o,
  output logic req_valid_o,
  output logic data_ready_o,
  output logic beat_o,
  output logic second_o,
  output logic clear_o,
  output logic capture_o,
  output logic done_o,
  output logic bad_o,
  output logic err_o
);
  import bbs_pkg::*;

  scan_state_e state_q, state_d;
  logic        second_q, second_d;
  logic        done_q, done_d;
  logic        bad_q, bad_d;
  logic        err_q, err_d;

  always_comb begin
    state_d      = state_q;
    second_d     = second_q;
    done_d       = 1'b0;
    bad_d        = bad_q;
    err_d        = err_q;
    capture_o    = 1'b0;
    clear_o      = 1'b0;
    req_valid_o  = (state_q == ST_REQ);
    data_ready_o = (state_q == ST_DATA);
    beat_o       = data_ready_o && data_valid_i;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          capture_o = 1'b1;
          bad_d     = 1'b0;
          err_d     = 1'b0;
          second_d  = 1'b0;
          state_d   = ST_REQ;
        end
      end
      ST_REQ: begin
        if (req_ready_i) begin
          clear_o = 1'b1;
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (beat_o) begin
          if (data_err_i) begin
            err_d   = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (last_i) begin
            if (page_bad_i) begin
              bad_d   = 1'b1;
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else if (second_q) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              second_d = 1'b1;
              state_d  = ST_REQ;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      second_q <= 1'b0;
      done_q   <= 1'b0;
      bad_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      second_q <= second_d;
      done_q   <= done_d;
      bad_q    <= bad_d;
      err_q    <= err_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign second_o = second_q;
  assign done_o   = done_q;
  assign bad_o    = bad_q;
  assign err_o    = err_q;

endmodule

// File: rtl/bad_block_scanner.sv
module bad_block_scanner #(
  parameter int BLK_W  = 10,
  parameter int PPB_W  = 8,
  parameter int SPR_W  = 8,
  parameter int COL_W  = 13,
  parameter int PAGE_W = BLK_W + PPB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_start_i,
  input  logic [BLK_W-1:0]  scan_block_i,
  input  logic              scan_full_i,
  input  logic [PPB_W-1:0]  pages_per_blk_i,
  input  logic [SPR_W-1:0]  spare_bytes_i,
  input  logic [COL_W-1:0]  page_bytes_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [PAGE_W-1:0] rd_req_page_o,
  output logic [COL_W-1:0]  rd_req_col_o,
  output logic [SPR_W-1:0]  rd_req_len_o,
  input  logic              rd_data_valid_i,
  output logic              rd_data_ready_o,
  input  logic [7:0]        rd_data_i,
  input  logic              rd_data_err_i,
  output logic              scan_busy_o,
  output logic              scan_done_o,
  output logic              scan_bad_o,
  output logic              scan_err_o
);
  logic [BLK_W-1:0] blk_q;
  logic [PPB_W-1:0] ppb_q;
  logic [SPR_W-1:0] spr_q;
  logic [COL_W-1:0] col_q;
  logic             full_q;

  logic capture, clear, beat, second, last_beat, page_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      ppb_q  <= '0;
      spr_q  <= '0;
      col_q  <= '0;
      full_q <= 1'b0;
    end else if (capture) begin
      blk_q  <= scan_block_i;
      ppb_q  <= pages_per_blk_i;
      spr_q  <= spare_bytes_i;
      col_q  <= page_bytes_i;
      full_q <= scan_full_i;
    end
  end

  bbs_page_sel #(
    .BLK_W (BLK_W),
    .PPB_W (PPB_W),
    .PAGE_W(PAGE_W)
  ) u_page_sel (
    .blk_i   (blk_q),
    .ppb_i   (ppb_q),
    .full_i  (full_q),
    .second_i(second),
    .page_o  (rd_req_page_o)
  );

  bbs_byte_inspect #(
    .SPR_W(SPR_W)
  ) u_inspect (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear),
    .beat_i    (beat),
    .full_i    (full_q),
    .data_i    (rd_data_i),
    .len_i     (spr_q),
    .last_o    (last_beat),
    .page_bad_o(page_bad)
  );

  bbs_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (scan_start_i),
    .req_ready_i (rd_req_ready_i),
    .data_valid_i(rd_data_valid_i),
    .data_err_i  (rd_data_err_i),
    .last_i      (last_beat),
    .page_bad_i  (page_bad),
    .busy_o      (scan_busy_o),
    .req_valid_o (rd_req_valid_o),
    .data_ready_o(rd_data_ready_o),
    .beat_o      (beat),
    .second_o    (second),
    .clear_o     (clear),
    .capture_o   (capture),
    .done_o      (scan_done_o),
    .bad_o       (scan_bad_o),
    .err_o       (scan_err_o)
  );

  assign rd_req_col_o = col_q;
  assign rd_req_len_o = spr_q;

endmodule

// File: rtl/bbs_scan_checker.sv
module bbs_scan_checker #(
  parameter int SPR_W  = 8,
  parameter int PAGE_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_start_i,
  input logic              rd_req_valid_o,
  input logic              rd_req_ready_i,
  input logic [PAGE_W-1:0] rd_req_page_o,
  input logic [SPR_W-1:0]  rd_req_len_o,
  input logic              rd_data_valid_i,
  input logic              rd_data_ready_o,
  input logic              rd_data_err_i,
  input logic              scan_busy_o,
  input logic              scan_done_o,
  input logic              scan_bad_o,
  input logic              scan_err_o
);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done_o |=> !scan_done_o);

  assert_bad_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scan_bad_o) || $rose(scan_err_o)) |-> scan_done_o);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scan_bad_o) || $fell(scan_err_o)) |-> ($past(scan_start_i) && !$past(scan_busy_o)));

  assert_verdict_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_bad_o && scan_err_o));

  assert_err_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_valid_i && rd_data_ready_o && rd_data_err_i)
      |=> (scan_done_o && scan_err_o && !scan_busy_o));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && !rd_req_ready_i)
      |=> (rd_req_valid_o && $stable(rd_req_page_o) && $stable(rd_req_len_o)));

  assert_phase_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid_o && rd_data_ready_o));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_busy_o |-> (!rd_req_valid_o && !rd_data_ready_o));

endmodule

bind bad_block_scanner bbs_scan_checker #(
  .SPR_W (SPR_W),
  .PAGE_W(PAGE_W)
) u_scan_checker (.*);

// File: tb/tb_bad_block_scanner.sv
`timescale 1ns/1ps
module tb_bad_block_scanner;
  localparam int BLK_W  = 10;
  localparam int PPB_W  = 8;
  localparam int SPR_W  = 8;
  localparam int COL_W  = 13;
  localparam int PAGE_W = BLK_W + PPB_W;

  logic clk, rst_n;
  logic scan_start_i, scan_full_i;
  logic [BLK_W-1:0]  scan_block_i;
  logic [PPB_W-1:0]  pages_per_blk_i;
  logic [SPR_W-1:0]  spare_bytes_i;
  logic [COL_W-1:0]  page_bytes_i;
  logic rd_req_valid_o, rd_req_ready_i;
  logic [PAGE_W-1:0] rd_req_page_o;
  logic [COL_W-1:0]  rd_req_col_o;
  logic [SPR_W-1:0]  rd_req_len_o;
  logic rd_data_valid_i, rd_data_ready_o, rd_data_err_i;
  logic [7:0] rd_data_i;
  logic scan_busy_o, scan_done_o, scan_bad_o, scan_err_o;

  bad_block_scanner #(.BLK_W(BLK_W), .PPB_W(PPB_W), .SPR_W(SPR_W), .COL_W(COL_W)) dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  int done_cnt = 0;
  bit prev_done = 1'b0;
  int gap_sel = 0;

  // flash model: two zero markers and one error marker (page, index); -1 = none
  int zp0 = -1, zi0 = -1, zp1 = -1, zi1 = -1, ep = -1, ei = -1;
  int cur_spr = 1, cur_psz = 0;

  int unsigned exp_pages[$];
  logic [1:0]  exp_verd[$];   // {bad, err}

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model_byte(input int p, input int i);
    if ((p == zp0 && i == zi0) || (p == zp1 && i == zi1)) return 8'h00;
    return 8'hA5 ^ 8'(i);
  endfunction

  // scoreboard monitor: verdicts
  always @(negedge clk) begin
    if (rst_n) begin
      if (scan_done_o) begin
        logic [1:0] v;
        chk(!prev_done, "R8", "done wider than one cycle", 1, 0);
        if (exp_verd.size() == 0) begin
          chk(1'b0, "R8", "unexpected done", 1, 0);
        end else begin
          v = exp_verd.pop_front();
          chk(scan_bad_o == v[1], "R3/R5/R6", "bad verdict", scan_bad_o, v[1]);
          chk(scan_err_o == v[0], "R7", "error verdict", scan_err_o, v[0]);
        end
        chk(exp_pages.size() == 0, "R6", "pages left unrequested", exp_pages.size(), 0);
        done_cnt++;
      end
      prev_done = scan_done_o;
    end
  end

  // flash read-port model: checks each request and streams spare bytes
  initial begin
    rd_req_ready_i  = 1'b0;
    rd_data_valid_i = 1'b0;
    rd_data_i       = 8'h00;
    rd_data_err_i   = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && rd_req_valid_o) begin
        int pg;
        int len;
        bit stop;
        pg  = int'(rd_req_page_o);
        len = int'(rd_req_len_o);
        if (exp_pages.size() == 0) begin
          chk(1'b0, "R6", "extra page request", pg, -1);
        end else begin
          int unsigned e;
          e = exp_pages.pop_front();
          chk(pg == int'(e), "R1/R2/R4", "requested page", pg, e);
        end
        chk(int'(rd_req_col_o) == cur_psz, "R1", "request column", rd_req_col_o, cur_psz);
        chk(len == cur_spr, "R1", "request length", len, cur_spr);
        gap_sel++;
        for (int g = 0; g < (gap_sel % 3); g++) begin
          @(negedge clk);
          chk(rd_req_valid_o && int'(rd_req_page_o) == pg, "R10", "request not held", rd_req_page_o, pg);
          chk(!rd_data_ready_o, "R10", "data ready during request", rd_data_ready_o, 0);
        end
        rd_req_ready_i = 1'b1;
        @(negedge clk);
        rd_req_ready_i = 1'b0;
        stop = 1'b0;
        for (int i = 0; i < len && !stop; i++) begin
          if ((gap_sel % 2 == 1) && (i % 4 == 3)) @(negedge clk);
          chk(rd_data_ready_o, "R10", "data ready low in data phase", rd_data_ready_o, 1);
          rd_data_valid_i = 1'b1;
          rd_data_i       = model_byte(pg, i);
          rd_data_err_i   = (pg == ep && i == ei);
          stop            = rd_data_err_i;
          @(negedge clk);
          rd_data_valid_i = 1'b0;
          rd_data_err_i   = 1'b0;
        end
        if (stop) chk(!rd_data_ready_o, "R7", "beats still accepted after error", rd_data_ready_o, 0);
      end
    end
  end

  task automatic run_scan(input int blk, input bit full, input int ppb, input int spr,
                          input int psz, input bit poke);
    int pages[2];
    bit bad, err, fin;
    int start_cnt;
    pages[0] = blk * ppb;
    pages[1] = full ? pages[0] + ppb - 1 : pages[0] + 1;
    bad = 0; err = 0; fin = 0;
    for (int k = 0; k < 2 && !fin; k++) begin
      bit pbad;
      pbad = 0;
      exp_pages.push_back(pages[k]);
      for (int i = 0; i < spr && !fin; i++) begin
        if (pages[k] == ep && i == ei) begin
          err = 1; fin = 1;
        end else if (model_byte(pages[k], i) == 8'h00 && (full || i == 0)) begin
          pbad = 1;
        end
      end
      if (!fin && pbad) begin
        bad = 1; fin = 1;
      end
    end
    exp_verd.push_back({bad, err});
    cur_spr = spr;
    cur_psz = psz;
    start_cnt = done_cnt;

    @(negedge clk);
    scan_start_i    = 1'b1;
    scan_block_i    = BLK_W'(blk);
    scan_full_i     = full;
    pages_per_blk_i = PPB_W'(ppb);
    spare_bytes_i   = SPR_W'(spr);
    page_bytes_i    = COL_W'(psz);
    @(negedge clk);
    scan_start_i = 1'b0;
    chk(!scan_bad_o && !scan_err_o, "R8", "flags not cleared at start",
        {scan_bad_o, scan_err_o}, 0);
    if (poke) begin
      // R9: second start while busy, with other block and policy
      @(negedge clk);
      chk(scan_busy_o, "R9", "busy during scan", scan_busy_o, 1);
      scan_start_i = 1'b1;
      scan_block_i = BLK_W'(blk + 1);
      scan_full_i  = !full;
      @(negedge clk);
      scan_start_i = 1'b0;
    end
    for (int t = 0; t < 4000 && done_cnt == start_cnt; t++) @(negedge clk);
    chk(done_cnt != start_cnt, "R8", "watchdog: no done", done_cnt, start_cnt + 1);
    repeat (3) @(negedge clk);
    chk(scan_bad_o == bad, "R8", "bad not held after done", scan_bad_o, bad);
    chk(scan_err_o == err, "R8", "err not held after done", scan_err_o, err);
    chk(!scan_busy_o, "R8", "busy after done", scan_busy_o, 0);
  endtask

  task automatic set_marks(input int a, input int b, input int c, input int d,
                           input int e, input int f);
    zp0 = a; zi0 = b; zp1 = c; zi1 = d; ep = e; ei = f;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    scan_start_i = 1'b0; scan_block_i = '0; scan_full_i = 1'b0;
    pages_per_blk_i = '0; spare_bytes_i = '0; page_bytes_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({scan_busy_o, scan_done_o, scan_bad_o, scan_err_o, rd_req_valid_o, rd_data_ready_o} == 6'b0,
        "R11", "reset state",
        {scan_busy_o, scan_done_o, scan_bad_o, scan_err_o, rd_req_valid_o, rd_data_ready_o}, 0);

    // R1 R2: full policy, clean block -> pages 24 and 31, good
    set_marks(-1, -1, -1, -1, -1, -1);
    run_scan(3, 1'b1, 8, 16, 2048, 1'b0);
    // R3: zero mid-spare of last page -> bad after both pages
    set_marks(31, 9, -1, -1, -1, -1);
    run_scan(3, 1'b1, 8, 16, 2048, 1'b0);
    // R3 R6: zero in last byte of first page -> bad, one request only
    set_marks(24, 15, -1, -1, -1, -1);
    run_scan(3, 1'b1, 8, 16, 2048, 1'b0);
    // R5 R4: legacy, zeros off byte 0 ignored -> pages 40, 41, good
    set_marks(40, 4, 41, 7, -1, -1);
    run_scan(5, 1'b0, 8, 16, 512, 1'b0);
    // R4: legacy, byte 0 of second page zero -> bad
    set_marks(41, 0, -1, -1, -1, -1);
    run_scan(5, 1'b0, 8, 16, 512, 1'b0);
    // R6: legacy, byte 0 of first page zero -> bad, one request
    set_marks(40, 0, -1, -1, -1, -1);
    run_scan(5, 1'b0, 8, 16, 512, 1'b0);
    // R7: error mid first page in full policy
    set_marks(-1, -1, -1, -1, 24, 3);
    run_scan(3, 1'b1, 8, 16, 2048, 1'b0);
    // R7: error and zero on the same beat -> error wins
    set_marks(41, 0, -1, -1, 41, 0);
    run_scan(5, 1'b0, 8, 16, 512, 1'b0);
    // R2: one page per block -> page 7 read twice
    set_marks(-1, -1, -1, -1, -1, -1);
    run_scan(7, 1'b1, 1, 8, 4096, 1'b0);
    // R9: start while busy ignored
    set_marks(-1, -1, 13, 2, -1, -1);
    run_scan(3, 1'b1, 4, 6, 2048, 1'b1);
    // R1 R2: wide geometry -> pages 64000 and 64063
    set_marks(-1, -1, -1, -1, -1, -1);
    run_scan(1000, 1'b1, 64, 4, 8000, 1'b0);
    // R5: legacy, single spare byte, nonzero -> good
    run_scan(9, 1'b0, 32, 1, 256, 1'b1);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule